// File: doc/BRIEF.md
# Consolidated Add and Logic Unit

This block is the integer arithmetic and bitwise logic slice of an execution pipeline. All add and subtract forms go through one adder that evaluates `(A xor I) + B + C`. I is either all zeros or all ones. B comes from the operand port or from the constant 0 or -1. C is zero, one or the carry stored by an earlier instruction. Subtract-from inverts A and sets C to one. The add-minus-one forms pick B = -1 and take C from the stored carry. Extended and carrying forms differ only in how C is chosen.

The logic forms use three gates: AND, OR and XOR. An optional inversion on the B input and an optional inversion on the output are placed around these gates. Together they give AND, AND-with-complement, NAND, OR, OR-with-complement, NOR, XOR and equivalence. The decode stage drives the select fields. The unit captures the result in one output register when the input strobe is high, and flags it one cycle later.

The carry out of the top bit serves full-width operations. The carry out of the lower half (bit 31 at the default width) serves 32-bit operations. Both are registered together with the result.

Top module: `addlogic_unit`

## Requirements
- R1: With `op_sel` = 0 (arithmetic), `result` equals (A' + B' + C) modulo 2^WIDTH. A' is `a` when `inv_a` = 0 and the bitwise complement of `a` when `inv_a` = 1.
- R2: The B' source follows `b_src`: 0 selects port `b`, 1 selects all zeros, 2 selects all ones, and 3 selects port `b`.
- R3: The carry-in C follows `c_src`: 0 gives 0, 1 gives 1, 2 gives the `carry_in` port, and 3 gives 0.
- R4: For arithmetic, `carry_hi` is the carry out of bit WIDTH-1 and `carry_lo` is the carry out of bit LOW_WIDTH-1 of the same sum.
- R5: With `op_sel` = 1, 2 or 3, `result` is A AND B'', A OR B'' or A XOR B'' respectively. B'' is `b` complemented when `inv_b_logic` = 1. The whole value is then complemented when `inv_out` = 1.
- R6: `inv_a`, `b_src`, `c_src` and `carry_in` have no effect on logic operations. `inv_b_logic` and `inv_out` have no effect on arithmetic.
- R7: For logic operations, both `carry_hi` and `carry_lo` are 0.
- R8: The outputs take the value for the inputs presented with `in_valid` high at one rising edge. They show that value after that edge, and `res_valid` is high for exactly the following cycle.
- R9: A cycle with `in_valid` low leaves `result`, `carry_hi` and `carry_lo` unchanged and drives `res_valid` low in the next cycle.
- R10: While `rst_n` is low at a rising edge, `res_valid`, `result`, `carry_hi` and `carry_lo` clear to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe; the output register loads when high |
| op_sel | input | 2 | 0 arithmetic, 1 AND, 2 OR, 3 XOR |
| inv_a | input | 1 | Complement A in the adder |
| b_src | input | 2 | Adder B source: 0/3 port b, 1 zero, 2 all ones |
| c_src | input | 2 | Adder carry-in: 0/3 zero, 1 one, 2 carry_in |
| carry_in | input | 1 | Stored carry bit from earlier work |
| inv_b_logic | input | 1 | Complement B before the logic gate |
| inv_out | input | 1 | Complement the logic gate output |
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| res_valid | output | 1 | High one cycle after an accepted strobe |
| result | output | WIDTH | Registered result |
| carry_hi | output | 1 | Registered carry out of bit WIDTH-1 |
| carry_lo | output | 1 | Registered carry out of bit LOW_WIDTH-1 |

## Verification
Every result, both carries and `res_valid` are due at the first rising edge after the inputs are driven. There is one register between the inputs and all outputs. The bench changes inputs on a falling edge and reads the outputs at the next falling edge. That is half a cycle after the capturing edge, so one vector is checked per cycle with a new strobe behind it. For the hold cases the strobe is dropped and the inputs are changed. The outputs are then read one falling edge later, where the previous value must still stand and `res_valid` must be low.

// File: rtl/ali_pkg.sv
// Shared encodings for the consolidated add and logic unit.
// Assumes the decode stage drives these codes on plain two-bit ports.
package ali_pkg;

    // Operation family: arithmetic or one of the three shared gates
    typedef enum logic [1:0] {
        ALI_OP_ARITH = 2'd0,
        ALI_OP_AND   = 2'd1,
        ALI_OP_OR    = 2'd2,
        ALI_OP_XOR   = 2'd3
    } ali_op_e;

    // Adder B source
    typedef enum logic [1:0] {
        ALI_B_REG  = 2'd0,
        ALI_B_ZERO = 2'd1,
        ALI_B_ONES = 2'd2,
        ALI_B_REG2 = 2'd3
    } ali_bsrc_e;

    // Adder carry-in source
    typedef enum logic [1:0] {
        ALI_C_ZERO  = 2'd0,
        ALI_C_ONE   = 2'd1,
        ALI_C_STORE = 2'd2,
        ALI_C_ZERO2 = 2'd3
    } ali_csrc_e;

endpackage

// File: rtl/ali_operand_prep.sv
// Operand conditioning for the adder: optional inversion of A, choice of
// B among the operand and two constants, and choice of the carry-in.
// Assumes: purely combinational; codes 3 of both selects alias safe defaults.
module ali_operand_prep
    import ali_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             inv_a,
    input  ali_bsrc_e        b_src,
    input  ali_csrc_e        c_src,
    input  logic             carry_in,
    output logic [WIDTH-1:0] a_eff,
    output logic [WIDTH-1:0] b_eff,
    output logic             c_eff
);

    // Apply the all-zeros or all-ones mask I to A
    always_comb begin
        a_eff = a ^ {WIDTH{inv_a}};
    end

    // Pick the B input of the adder
    always_comb begin
        unique case (b_src)
            ALI_B_ZERO: b_eff = '0;
            ALI_B_ONES: b_eff = '1;
            default:    b_eff = b;
        endcase
    end

    // Pick the carry-in of the adder
    always_comb begin
        unique case (c_src)
            ALI_C_ONE:   c_eff = 1'b1;
            ALI_C_STORE: c_eff = carry_in;
            default:     c_eff = 1'b0;
        endcase
    end

endmodule

// File: rtl/ali_adder.sv
// Two-segment adder. The low segment covers bits LOW_WIDTH-1..0 and its
// carry both feeds the high segment and leaves as the half-width carry.
// Assumes 0 < LOW_WIDTH < WIDTH.
module ali_adder #(
    parameter int WIDTH     = 64,
    parameter int LOW_WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_eff,
    input  logic [WIDTH-1:0] b_eff,
    input  logic             c_eff,
    output logic [WIDTH-1:0] sum,
    output logic             c_hi,
    output logic             c_lo
);

    localparam int HIGH_WIDTH = WIDTH - LOW_WIDTH;

    logic [LOW_WIDTH:0]  low_sum;
    logic [HIGH_WIDTH:0] high_sum;

    // Low segment with the selected carry-in
    always_comb begin
        low_sum = {1'b0, a_eff[LOW_WIDTH-1:0]}
                + {1'b0, b_eff[LOW_WIDTH-1:0]}
                + {{LOW_WIDTH{1'b0}}, c_eff};
    end

    // High segment chained on the low carry
    always_comb begin
        high_sum = {1'b0, a_eff[WIDTH-1:LOW_WIDTH]}
                 + {1'b0, b_eff[WIDTH-1:LOW_WIDTH]}
                 + {{HIGH_WIDTH{1'b0}}, low_sum[LOW_WIDTH]};
    end

    // Join the segments and expose both carries
    always_comb begin
        sum  = {high_sum[HIGH_WIDTH-1:0], low_sum[LOW_WIDTH-1:0]};
        c_hi = high_sum[HIGH_WIDTH];
        c_lo = low_sum[LOW_WIDTH];
    end

endmodule

// File: rtl/ali_logic.sv
// Shared bitwise gate set: one AND, one OR and one XOR behind an optional
// complement of B and followed by an optional complement of the output.
// Assumes the arithmetic code selects nothing here (output forced to 0).
module ali_logic
    import ali_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  ali_op_e          op,
    input  logic             inv_b,
    input  logic             inv_out,
    output logic [WIDTH-1:0] y
);

    logic [WIDTH-1:0] b_cond;
    logic [WIDTH-1:0] gate_out;

    // Condition the B input
    always_comb begin
        b_cond = b ^ {WIDTH{inv_b}};
    end

    // Evaluate the selected gate bit by bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (op)
                ALI_OP_AND: gate_out[i] = a[i] & b_cond[i];
                ALI_OP_OR:  gate_out[i] = a[i] | b_cond[i];
                ALI_OP_XOR: gate_out[i] = a[i] ^ b_cond[i];
                default:    gate_out[i] = 1'b0;
            endcase
        end
    end

    // Apply the output complement
    always_comb begin
        y = gate_out ^ {WIDTH{inv_out}};
    end

endmodule

// File: rtl/addlogic_unit.sv
// Consolidated add and logic unit: one adder for every add/subtract form,
// one gate set for every bitwise form, and one output register loaded on
// the input strobe. Assumes synchronous active-low reset and that the
// inputs are stable around the rising edge at which in_valid is sampled.
module addlogic_unit
    import ali_pkg::*;
#(
    parameter int WIDTH     = 64,
    parameter int LOW_WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op_sel,
    input  logic             inv_a,
    input  logic [1:0]       b_src,
    input  logic [1:0]       c_src,
    input  logic             carry_in,
    input  logic             inv_b_logic,
    input  logic             inv_out,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             res_valid,
    output logic [WIDTH-1:0] result,
    output logic             carry_hi,
    output logic             carry_lo
);

    ali_op_e          op;
    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] b_eff;
    logic             c_eff;
    logic [WIDTH-1:0] sum;
    logic             add_c_hi;
    logic             add_c_lo;
    logic [WIDTH-1:0] logic_y;
    logic             is_arith;
    logic [WIDTH-1:0] next_result;
    logic             next_c_hi;
    logic             next_c_lo;

    // Decode the operation family
    always_comb begin
        op       = ali_op_e'(op_sel);
        is_arith = (op == ALI_OP_ARITH);
    end

    ali_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .a        (a),
        .b        (b),
        .inv_a    (inv_a),
        .b_src    (ali_bsrc_e'(b_src)),
        .c_src    (ali_csrc_e'(c_src)),
        .carry_in (carry_in),
        .a_eff    (a_eff),
        .b_eff    (b_eff),
        .c_eff    (c_eff)
    );

    ali_adder #(.WIDTH(WIDTH), .LOW_WIDTH(LOW_WIDTH)) u_add (
        .a_eff (a_eff),
        .b_eff (b_eff),
        .c_eff (c_eff),
        .sum   (sum),
        .c_hi  (add_c_hi),
        .c_lo  (add_c_lo)
    );

    ali_logic #(.WIDTH(WIDTH)) u_logic (
        .a       (a),
        .b       (b),
        .op      (op),
        .inv_b   (inv_b_logic),
        .inv_out (inv_out),
        .y       (logic_y)
    );

    // Select between the two paths; logic forms carry nothing out
    always_comb begin
        next_result = is_arith ? sum : logic_y;
        next_c_hi   = is_arith & add_c_hi;
        next_c_lo   = is_arith & add_c_lo;
    end

    // Output register: load on strobe, pulse the valid flag one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            result    <= '0;
            carry_hi  <= 1'b0;
            carry_lo  <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                result   <= next_result;
                carry_hi <= next_c_hi;
                carry_lo <= next_c_lo;
            end
        end
    end

endmodule

// File: rtl/ali_checker.sv
// Temporal checks for the consolidated add and logic unit, bound to every
// instance of the top module. Assumes the same reset as the design.
module ali_checker #(
    parameter int WIDTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       op_sel,
    input logic             inv_a,
    input logic [1:0]       b_src,
    input logic [1:0]       c_src,
    input logic             inv_b_logic,
    input logic             inv_out,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             res_valid,
    input logic [WIDTH-1:0] result,
    input logic             carry_hi,
    input logic             carry_lo
);

    // A plus zero plus zero returns A with no carry (R1)
    assert_add_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd0 && !inv_a && b_src == 2'd1 && c_src != 2'd1 && c_src != 2'd2)
        |=> (result == $past(a) && !carry_hi && !carry_lo));

    // Complemented A plus all ones plus one returns complemented A (R2)
    assert_minus_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd0 && inv_a && b_src == 2'd2 && c_src == 2'd1)
        |=> (result == ~$past(a)));

    // XOR of equal operands without inversions is zero (R5)
    assert_xor_self_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd3 && !inv_b_logic && !inv_out && a == b)
        |=> (result == '0));

    // Logic forms produce no carries (R7)
    assert_logic_no_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel != 2'd0) |=> (!carry_hi && !carry_lo));

    // Strobe yields a valid flag the next cycle (R8)
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    // No strobe: flag low and outputs held (R9)
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && $stable(result) && $stable(carry_hi) && $stable(carry_lo)));

endmodule

bind addlogic_unit ali_checker #(.WIDTH(WIDTH)) u_ali_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_sel      (op_sel),
    .inv_a       (inv_a),
    .b_src       (b_src),
    .c_src       (c_src),
    .inv_b_logic (inv_b_logic),
    .inv_out     (inv_out),
    .a           (a),
    .b           (b),
    .res_valid   (res_valid),
    .result      (result),
    .carry_hi    (carry_hi),
    .carry_lo    (carry_lo)
);

// File: tb/addlogic_unit_bench.sv
`timescale 1ns/1ps
module addlogic_unit_bench;

    localparam int W = 8;
    localparam int L = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   op_sel;
    logic         inv_a;
    logic [1:0]   b_src;
    logic [1:0]   c_src;
    logic         carry_in;
    logic         inv_b_logic;
    logic         inv_out;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         res_valid;
    logic [W-1:0] result;
    logic         carry_hi;
    logic         carry_lo;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    addlogic_unit #(.WIDTH(W), .LOW_WIDTH(L)) u_addlogic_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .inv_a(inv_a), .b_src(b_src), .c_src(c_src), .carry_in(carry_in),
        .inv_b_logic(inv_b_logic), .inv_out(inv_out), .a(a), .b(b),
        .res_valid(res_valid), .result(result), .carry_hi(carry_hi),
        .carry_lo(carry_lo)
    );

    // Behavioural model written from the requirements
    task automatic model(input logic [W-1:0] ma, input logic [W-1:0] mb,
                         input logic [1:0] op, input logic ia,
                         input logic [1:0] bs, input logic [1:0] cs,
                         input logic ci, input logic ib, input logic io,
                         output logic [W-1:0] r, output logic h, output logic l);
        logic [W-1:0] ae, be, bl;
        logic         c;
        logic [W:0]   full;
        logic [L:0]   low;
        if (op == 2'd0) begin
            ae = ia ? ~ma : ma;
            case (bs)
                2'd1:    be = '0;
                2'd2:    be = '1;
                default: be = mb;
            endcase
            case (cs)
                2'd1:    c = 1'b1;
                2'd2:    c = ci;
                default: c = 1'b0;
            endcase
            full = {1'b0, ae} + {1'b0, be} + {{W{1'b0}}, c};
            low  = {1'b0, ae[L-1:0]} + {1'b0, be[L-1:0]} + {{L{1'b0}}, c};
            r = full[W-1:0];
            h = full[W];
            l = low[L];
        end else begin
            bl = ib ? ~mb : mb;
            case (op)
                2'd1:    r = ma & bl;
                2'd2:    r = ma | bl;
                default: r = ma ^ bl;
            endcase
            if (io) r = ~r;
            h = 1'b0;
            l = 1'b0;
        end
    endtask

    task automatic check(input string tag, input logic [W-1:0] er,
                         input logic eh, input logic el, input logic ev);
        checks++;
        if (result !== er || carry_hi !== eh || carry_lo !== el || res_valid !== ev) begin
            fails++;
            $display("FAIL %s: got r=%h hi=%b lo=%b v=%b, expected r=%h hi=%b lo=%b v=%b",
                     tag, result, carry_hi, carry_lo, res_valid, er, eh, el, ev);
        end
    endtask

    logic [W-1:0] last_r;
    logic         last_h, last_l;

    // Drive one vector at a falling edge and check it at the next one
    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb,
                         input logic [1:0] op, input logic ia,
                         input logic [1:0] bs, input logic [1:0] cs,
                         input logic ci, input logic ib, input logic io,
                         input string tag);
        logic [W-1:0] er;
        logic eh, el;
        a = va; b = vb; op_sel = op; inv_a = ia; b_src = bs; c_src = cs;
        carry_in = ci; inv_b_logic = ib; inv_out = io; in_valid = 1'b1;
        model(va, vb, op, ia, bs, cs, ci, ib, io, er, eh, el);
        @(negedge clk);
        check(tag, er, eh, el, 1'b1);
        last_r = er; last_h = eh; last_l = el;
    endtask

    // Watchdog: an expired run is a failed check
    initial begin
        repeat (185000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] bset [6];
        bset[0] = 8'h00; bset[1] = 8'hFF; bset[2] = 8'h80;
        bset[3] = 8'h7F; bset[4] = 8'h5A; bset[5] = 8'h0F;

        rst_n = 1'b0; in_valid = 1'b0; op_sel = 2'd0; inv_a = 1'b0;
        b_src = 2'd0; c_src = 2'd0; carry_in = 1'b0; inv_b_logic = 1'b0;
        inv_out = 1'b0; a = 8'hA5; b = 8'h3C;
        repeat (3) @(negedge clk);
        check("R10 reset clears outputs", '0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 R9 no strobe after reset", '0, 1'b0, 1'b0, 1'b0);

        // Sweep all A values against the B corner set through every form
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 6; ib++) begin
                logic [W-1:0] va;
                va = W'(ia);
                for (int k = 0; k < 64; k++) begin
                    logic [1:0] bs_k, cs_k;
                    bs_k = k[2:1];
                    cs_k = k[4:3];
                    // arithmetic, with logic-only controls toggled (R6)
                    apply(va, bset[ib], 2'd0, k[0], bs_k, cs_k, k[5],
                          va[0], va[1], "R1 R2 R3 R4 R6 R8 arithmetic");
                end
                for (int k = 0; k < 12; k++) begin
                    logic [1:0] op_k;
                    op_k = 2'(k % 3 + 1);
                    // logic, with adder-only controls toggled (R6)
                    apply(va, bset[ib], op_k, va[2], va[4:3], va[6:5], va[7],
                          k[2], k[3], "R5 R6 R7 R8 logic");
                end
            end
        end

        // Hold: drop the strobe, change every input, outputs must stand
        for (int h = 0; h < 4; h++) begin
            apply(8'hFF, 8'h01, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0,
                  "R4 R8 carry out of both segments");
            in_valid = 1'b0;
            a = W'(h * 37); b = W'(h * 91); op_sel = 2'(h);
            inv_out = h[0];
            @(negedge clk);
            check("R9 hold without strobe", last_r, last_h, last_l, 1'b0);
            @(negedge clk);
            check("R9 hold second idle cycle", last_r, last_h, last_l, 1'b0);
        end

        // Reset in mid-run clears a non-zero result
        apply(8'h7F, 8'h7F, 2'd2, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1,
              "R5 NOR before reset");
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset after activity", '0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule